// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table and Pending Controller

This block holds a table of up to 32 interrupt vectors and an array of pending flags. Both sit in one 4 KB register window on a simple 32-bit memory-mapped slave port. Each vector entry carries a 64-bit message address, a 32-bit message payload and a mask flag. Device logic raises per-vector interrupt requests. The block turns each request into one message write on a request/acknowledge master port. If the vector is masked, it records the request as pending instead.

Device logic claims and releases vectors through a small port. Each vector keeps a saturating use counter, and a request on a vector nobody has claimed is dropped. A global enable register gates the whole request path. When software clears the mask of an entry that has a pending flag, the block replays the message automatically. A replay takes priority over new requests.

Top module: `msix_ctrl`

## Requirements
- R1: Vector n occupies the 16 bytes starting at byte offset 16*n. Word 0 of the entry holds the message address bits 31:0, word 1 holds address bits 63:32, word 2 holds the payload and word 3 holds the control word. Only bit 0 of the control word, the mask, is stored; the other control bits read as zero. A read of an offset in the lower half of the window that lies outside every entry returns zero.
- R2: The 32-bit word at offset 0x800 shows the pending flags, with bit v belonging to vector v (the byte at 0x800 + v/8, bit v mod 8). This word is read-only, and writes to it are discarded.
- R3: An access is honoured only when all four byte enables are set and the address is word aligned. Any other read returns zero, and any other write changes nothing.
- R4: Every read request produces read-valid, with its data, in the clock cycle that follows it.
- R5: A claim raises the use counter of a vector whose number is below the configured count, and the counter saturates at its maximum. A release lowers the counter only when the counter is non-zero. Claims and releases on out-of-range vectors have no effect.
- R6: An accepted request is dropped without effect in three cases: the vector number is at or above the configured count, the vector's use counter is zero, or the global enable is low.
- R7: An accepted, valid request on a masked vector sets that vector's pending flag and emits no message.
- R8: An accepted, valid request on an unmasked vector raises the message-valid output on the next clock. The message address is {word 1, word 0} of the entry and the data is its payload. Address and data stay stable until the acknowledge.
- R9: When an entry is unmasked while its pending flag is set, the pending flag is cleared and that entry's message is issued. This does not depend on the use count or the enable. When several entries qualify, the lowest-numbered vector goes first.
- R10: At most one message is outstanding. Request-ready is low while a message waits for its acknowledge and while any replay is waiting.
- R11: Reset clears every table word, every mask, every pending flag, every use counter, the enable and the message-valid output.
- R12: A write strobe on the enable port loads the global enable, which is visible on its output after the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_count | input | 6 | Number of vectors in use (1..32) |
| enable_we | input | 1 | Load strobe for the global enable |
| enable_d | input | 1 | New global enable value |
| enable_q | output | 1 | Current global enable |
| s_valid | input | 1 | Slave access request |
| s_write | input | 1 | 1 = write, 0 = read |
| s_addr | input | 12 | Byte address within the window |
| s_be | input | 4 | Byte enables |
| s_wdata | input | 32 | Write data |
| s_rvalid | output | 1 | Read data valid |
| s_rdata | output | 32 | Read data |
| use_valid | input | 1 | Claim/release strobe |
| use_claim | input | 1 | 1 = claim, 0 = release |
| use_vec | input | 5 | Vector being claimed or released |
| irq_valid | input | 1 | Interrupt request |
| irq_vec | input | 5 | Requesting vector |
| irq_ready | output | 1 | Request accepted this cycle |
| m_valid | output | 1 | Message write pending |
| m_addr | output | 64 | Message address |
| m_data | output | 32 | Message payload |
| m_ack | input | 1 | Message accepted |

## Verification
Read data is due one clock after the read request. A request accepted at a clock edge either shows a message on the next edge or shows nothing, and its pending flag becomes readable with a read issued on the following cycle. A table write that unmasks a pending entry starts the replay on the second edge after the write. The bench drives all inputs on the falling edge. A behavioural model advances on the same rising edge as the design, and model and design outputs are compared on every falling edge. The directed checks sample exactly at the falling edge where each result is due.

// File: rtl/msix_ctrl.sv
module msix_ctrl #(
  parameter int NVEC = 32,
  parameter int UW   = 4,
  localparam int IW  = $clog2(NVEC),
  localparam int CW  = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_count,
  input  logic          enable_we,
  input  logic          enable_d,
  output logic          enable_q,
  input  logic          s_valid,
  input  logic          s_write,
  input  logic [11:0]   s_addr,
  input  logic [3:0]    s_be,
  input  logic [31:0]   s_wdata,
  output logic          s_rvalid,
  output logic [31:0]   s_rdata,
  input  logic          use_valid,
  input  logic          use_claim,
  input  logic [IW-1:0] use_vec,
  input  logic          irq_valid,
  input  logic [IW-1:0] irq_vec,
  output logic          irq_ready,
  output logic          m_valid,
  output logic [63:0]   m_addr,
  output logic [31:0]   m_data,
  input  logic          m_ack
);

  logic [31:0]   t_lo  [NVEC];
  logic [31:0]   t_hi  [NVEC];
  logic [31:0]   t_dat [NVEC];
  logic [UW-1:0] use_cnt [NVEC];
  logic [NVEC-1:0] t_mask, pend;

  wire          full   = s_valid && s_be == 4'hF && s_addr[1:0] == 2'b00;
  wire          in_tbl = s_addr[11:4] < 8'(NVEC);
  wire          in_pba = s_addr[11:2] == 10'h200;
  wire [IW-1:0] ent    = s_addr[4 +: IW];
  wire          tw     = full && s_write && in_tbl;

  wire [NVEC-1:0] rp = pend & ~t_mask;
  wire replay_any = |rp;
  logic [IW-1:0] rp_idx;

  always_comb begin
    rp_idx = '0;
    for (int i = NVEC - 1; i >= 0; i--)
      if (rp[i]) rp_idx = IW'(i);
  end

  assign irq_ready = !m_valid && !replay_any;
  wire irq_fire = irq_valid && irq_ready;
  wire irq_ok   = enable_q && (CW'(irq_vec) < cfg_count) && (use_cnt[irq_vec] != '0);
  wire use_in   = CW'(use_vec) < cfg_count;

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (full && in_tbl) begin
      case (s_addr[3:2])
        2'd0: rd_mux = t_lo[ent];
        2'd1: rd_mux = t_hi[ent];
        2'd2: rd_mux = t_dat[ent];
        default: rd_mux = {31'd0, t_mask[ent]};
      endcase
    end else if (full && in_pba) begin
      rd_mux = 32'(pend);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NVEC; i++) begin
        t_lo[i]    <= '0;
        t_hi[i]    <= '0;
        t_dat[i]   <= '0;
        use_cnt[i] <= '0;
      end
      t_mask   <= '0;
      pend     <= '0;
      enable_q <= 1'b0;
      m_valid  <= 1'b0;
      m_addr   <= '0;
      m_data   <= '0;
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
    end else begin
      if (tw) begin
        case (s_addr[3:2])
          2'd0: t_lo[ent]  <= s_wdata;
          2'd1: t_hi[ent]  <= s_wdata;
          2'd2: t_dat[ent] <= s_wdata;
          default: t_mask[ent] <= s_wdata[0];
        endcase
      end

      if (enable_we) enable_q <= enable_d;

      if (use_valid && use_in) begin
        if (use_claim) begin
          if (use_cnt[use_vec] != '1) use_cnt[use_vec] <= use_cnt[use_vec] + 1'b1;
        end else if (use_cnt[use_vec] != '0) begin
          use_cnt[use_vec] <= use_cnt[use_vec] - 1'b1;
        end
      end

      if (m_valid) begin
        if (m_ack) m_valid <= 1'b0;
      end else if (replay_any) begin
        m_valid      <= 1'b1;
        m_addr       <= {t_hi[rp_idx], t_lo[rp_idx]};
        m_data       <= t_dat[rp_idx];
        pend[rp_idx] <= 1'b0;
      end else if (irq_fire && irq_ok) begin
        if (t_mask[irq_vec]) begin
          pend[irq_vec] <= 1'b1;
        end else begin
          m_valid <= 1'b1;
          m_addr  <= {t_hi[irq_vec], t_lo[irq_vec]};
          m_data  <= t_dat[irq_vec];
        end
      end

      s_rvalid <= s_valid && !s_write;
      s_rdata  <= rd_mux;
    end
  end

endmodule

module msix_ctrl_chk #(
  parameter int NVEC = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable_q,
  input logic            s_valid,
  input logic            s_write,
  input logic            s_rvalid,
  input logic            irq_valid,
  input logic            irq_ready,
  input logic            m_valid,
  input logic [63:0]     m_addr,
  input logic [31:0]     m_data,
  input logic            m_ack,
  input logic [NVEC-1:0] pend,
  input logic [NVEC-1:0] t_mask
);

  a_r8_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ack |=> m_valid && $stable(m_addr) && $stable(m_data));

  a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ready |-> !m_valid);

  a_r7_pend_only_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~$past(t_mask)) == '0);

  a_r9_clear_sends: assert property (@(posedge clk) disable iff (!rst_n)
    |($past(pend) & ~pend) |-> m_valid && !$past(m_valid));

  a_r4_read_next: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && !s_write |=> s_rvalid);

  a_r6_disabled_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_q && irq_valid && irq_ready |=> !m_valid);

endmodule

bind msix_ctrl msix_ctrl_chk #(.NVEC(NVEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable_q(enable_q),
  .s_valid(s_valid), .s_write(s_write), .s_rvalid(s_rvalid),
  .irq_valid(irq_valid), .irq_ready(irq_ready),
  .m_valid(m_valid), .m_addr(m_addr), .m_data(m_data), .m_ack(m_ack),
  .pend(pend), .t_mask(t_mask)
);

// File: tb/msix_ctrl_tb.sv
`timescale 1ns/1ps
module msix_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic [5:0] cfg_count = 6'd4;
  logic enable_we = 0, enable_d = 0, enable_q;
  logic s_valid = 0, s_write = 0, s_rvalid;
  logic [11:0] s_addr = 0;
  logic [3:0] s_be = 0;
  logic [31:0] s_wdata = 0, s_rdata;
  logic use_valid = 0, use_claim = 0;
  logic [4:0] use_vec = 0, irq_vec = 0;
  logic irq_valid = 0, irq_ready, m_valid, m_ack = 0;
  logic [63:0] m_addr;
  logic [31:0] m_data;

  always #10 clk = ~clk;

  msix_ctrl u_dut (.*);

  int tests = 0, fails = 0, ack_pct = 100;
  string cur_req = "R11";
  bit started = 0;

  bit [31:0] mlo[32], mhi[32], mdat[32];
  bit mmask[32];
  bit [31:0] mpend;
  int muse[32];
  bit men, mmv, mrv;
  bit [63:0] mma;
  bit [31:0] mmd, mrd;

  function automatic bit m_rany();
    for (int v = 0; v < 32; v++) if (mpend[v] && !mmask[v]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (!rst_n) begin
      for (int v = 0; v < 32; v++) begin
        mlo[v] = 0; mhi[v] = 0; mdat[v] = 0; mmask[v] = 0; muse[v] = 0;
      end
      mpend = 0; men = 0; mmv = 0; mrv = 0; mma = 0; mmd = 0; mrd = 0;
    end else begin
      automatic bit rany = m_rany();
      automatic int rsel = 0;
      automatic bit rdy = !mmv && !rany;
      automatic bit fullacc = s_valid && s_be == 4'hF && s_addr[1:0] == 0;
      automatic int idx = int'(s_addr) / 16;
      automatic int w = int'(s_addr[3:2]);
      automatic bit [31:0] nrd = 0;
      for (int v = 31; v >= 0; v--) if (mpend[v] && !mmask[v]) rsel = v;
      if (fullacc && !s_write) begin
        if (s_addr < 12'd512) begin
          nrd = (w == 0) ? mlo[idx] : (w == 1) ? mhi[idx] : (w == 2) ? mdat[idx] : {31'd0, mmask[idx]};
        end else if (s_addr == 12'h800) nrd = mpend;
      end
      if (mmv) begin
        if (m_ack) mmv = 0;
      end else if (rany) begin
        mmv = 1; mma = {mhi[rsel], mlo[rsel]}; mmd = mdat[rsel]; mpend[rsel] = 0;
      end else if (irq_valid && rdy && men && irq_vec < cfg_count && muse[irq_vec] > 0) begin
        if (mmask[irq_vec]) mpend[irq_vec] = 1;
        else begin mmv = 1; mma = {mhi[irq_vec], mlo[irq_vec]}; mmd = mdat[irq_vec]; end
      end
      if (fullacc && s_write && s_addr < 12'd512) begin
        case (w)
          0: mlo[idx] = s_wdata;
          1: mhi[idx] = s_wdata;
          2: mdat[idx] = s_wdata;
          default: mmask[idx] = s_wdata[0];
        endcase
      end
      if (enable_we) men = enable_d;
      if (use_valid && use_vec < cfg_count) begin
        if (use_claim) begin if (muse[use_vec] < 15) muse[use_vec]++; end
        else if (muse[use_vec] > 0) muse[use_vec]--;
      end
      mrv = s_valid && !s_write;
      mrd = nrd;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      tests++;
      if (m_valid !== mmv || irq_ready !== (!mmv && !m_rany()) || enable_q !== men ||
          s_rvalid !== mrv || (mmv && (m_addr !== mma || m_data !== mmd)) ||
          (mrv && s_rdata !== mrd)) begin
        fails++;
        $display("FAIL %s model compare: actual mv=%b rdy=%b en=%b rv=%b addr=%0h data=%0h rd=%0h expected mv=%b en=%b rv=%b addr=%0h data=%0h rd=%0h",
                 cur_req, m_valid, irq_ready, enable_q, s_rvalid, m_addr, m_data, s_rdata,
                 mmv, men, mrv, mma, mmd, mrd);
      end
    end
    m_ack = ($urandom_range(99) < ack_pct);
  end

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk); s_valid = 1; s_write = 1; s_addr = a; s_wdata = d; s_be = be;
    @(negedge clk); s_valid = 0; s_write = 0;
  endtask

  task automatic rd(string req, logic [11:0] a, logic [31:0] exp, logic [3:0] be = 4'hF);
    @(negedge clk); s_valid = 1; s_write = 0; s_addr = a; s_be = be;
    @(negedge clk); s_valid = 0;
    check(req, {s_rvalid, s_rdata}, {1'b1, exp});
  endtask

  task automatic use_op(logic claim, logic [4:0] v);
    @(negedge clk); use_valid = 1; use_claim = claim; use_vec = v;
    @(negedge clk); use_valid = 0;
  endtask

  task automatic notify(logic [4:0] v);
    @(negedge clk); irq_valid = 1; irq_vec = v;
    @(negedge clk); irq_valid = 0;
  endtask

  task automatic set_en(logic e);
    @(negedge clk); enable_we = 1; enable_d = e;
    @(negedge clk); enable_we = 0;
  endtask

  task automatic settle();
    ack_pct = 100; repeat (3) @(negedge clk); ack_pct = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    ack_pct = 0;
    repeat (5) @(negedge clk);
    check("R11 reset msg", m_valid, 0);
    check("R11 reset ready", irq_ready, 1);
    check("R11 reset enable", enable_q, 0);
    rst_n = 1;
    rd("R11 table cleared", 12'h030, 0);

    cur_req = "R12"; set_en(1); check("R12 enable load", enable_q, 1);

    cur_req = "R1";
    wr(12'h030, 32'hA000_0030); wr(12'h034, 32'h0000_00FE); wr(12'h038, 32'hD00D_0003);
    rd("R1 lo", 12'h030, 32'hA000_0030);
    rd("R1 hi", 12'h034, 32'h0000_00FE);
    rd("R1 data", 12'h038, 32'hD00D_0003);
    wr(12'h03C, 32'hFFFF_FFFF); rd("R1 ctrl mask only", 12'h03C, 1);
    wr(12'h03C, 0); rd("R1 ctrl cleared", 12'h03C, 0);
    rd("R1 outside table", 12'h400, 0);

    cur_req = "R3";
    wr(12'h030, 32'h1234, 4'h3); rd("R3 partial write dropped", 12'h030, 32'hA000_0030);
    rd("R3 partial read zero", 12'h030, 0, 4'h1);
    rd("R4 read valid next cycle", 12'h038, 32'hD00D_0003);

    cur_req = "R6"; notify(3); check("R6 unclaimed drop", m_valid, 0);
    cur_req = "R8"; use_op(1, 3); notify(3);
    check("R8 msg valid", m_valid, 1);
    check("R8 msg addr", m_addr, 64'h0000_00FE_A000_0030);
    check("R8 msg data", m_data, 32'hD00D_0003);
    cur_req = "R10"; check("R10 ready low while outstanding", irq_ready, 0);
    repeat (3) @(negedge clk);
    check("R8 held without ack", m_valid, 1);
    settle();

    cur_req = "R5";
    use_op(0, 3); notify(3); check("R5 release drop", m_valid, 0);
    use_op(0, 3); use_op(1, 3); notify(3); check("R5 no wrap below zero", m_valid, 1);
    settle();
    use_op(1, 5); notify(5); check("R6 out of range drop", m_valid, 0);

    cur_req = "R7";
    wr(12'h03C, 1); notify(3); check("R7 masked no msg", m_valid, 0);
    rd("R2 pending bit3", 12'h800, 32'h8);
    wr(12'h800, 0); rd("R2 pba read-only", 12'h800, 32'h8);

    cur_req = "R9";
    wr(12'h03C, 0); @(negedge clk);
    check("R9 replay msg", m_valid, 1);
    check("R9 replay addr", m_addr, 64'h0000_00FE_A000_0030);
    settle();
    rd("R9 pending cleared", 12'h800, 0);

    cur_req = "R6"; set_en(0); notify(3); check("R6 disabled drop", m_valid, 0);

    cur_req = "R11";
    set_en(1);
    @(negedge clk); rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1;
    check("R11 enable cleared", enable_q, 0);
    rd("R11 entry cleared", 12'h030, 0);
    set_en(1); notify(3); check("R11 use count cleared", m_valid, 0);

    cur_req = "R9 random";
    cfg_count = 6; ack_pct = 50;
    for (int v = 0; v < 8; v++) use_op(1, 5'(v));
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      s_valid = 0; s_write = 0; use_valid = 0; irq_valid = 0;
      case ($urandom_range(3))
        0: begin
          s_valid = 1; s_write = $urandom_range(1);
          s_be = ($urandom_range(7) == 0) ? 4'h7 : 4'hF;
          s_addr = ($urandom_range(7) == 0) ? 12'h800 : 12'({$urandom_range(7), $urandom_range(3), 2'b00});
          s_wdata = ($urandom_range(1) == 1) ? 32'($urandom_range(1)) : $urandom;
        end
        1: begin use_valid = 1; use_claim = $urandom_range(1); use_vec = 5'($urandom_range(7)); end
        default: begin irq_valid = 1; irq_vec = 5'($urandom_range(7)); end
      endcase
    end
    @(negedge clk); s_valid = 0; use_valid = 0; irq_valid = 0;
    repeat (5) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule